// File: doc/BRIEF.md
# Link Frame Transmit Encapsulator

This block sits between a transport layer that produces frame payloads and a line encoder. It accepts payload Dwords over a valid/ready/last stream and emits a framed word stream. Each frame opens with a start primitive, carries the scrambled payload and then a scrambled 32-bit check word, and closes with an end primitive. Every output word has a control flag, so the encoder downstream can map primitives to special characters.

The check word is computed over the plain payload before any scrambling. The scrambler then masks both the payload and the check word. Primitives skip both the CRC and the scrambler. The scrambler and the CRC are reseeded each time a start primitive is issued. While the block emits the start primitive, the check word or the end primitive, it holds the upstream stalled.

Top module: `lnk_frame_tx`

## Requirements
- R1: After synchronous reset, `out_valid` and `in_ready` are both 0.
- R2: Each frame leaves as one start word (`out_ctrl`=1), then one data word (`out_ctrl`=0) per accepted payload Dword in arrival order, then one check word (`out_ctrl`=0), then one end word (`out_ctrl`=1). Frames do not interleave.
- R3: The check word, before masking, is a CRC with polynomial 0x04C11DB7 and initial value 0x52325032. It is reloaded at each start word, processes payload bit 31 first with no reflection and no final inversion, and covers only payload Dwords.
- R4: Each data word and the check word is XORed with a 32-bit mask from a 16-bit LFSR that is reloaded to 0xFFFF at each start word. Each mask bit is the register's bit 15. The register then shifts left with bit 15 ^ bit 14 ^ bit 12 ^ bit 3 entering at bit 0. The first bit produced is mask bit 31, and 32 shifts occur per masked word only.
- R5: Primitives go out unmasked. The start word is `SOF_WORD` (default 0x3737B57C) and the end word is `EOF_WORD` (default 0xD5D5B57C).
- R6: `in_ready` is 0 until the frame's start word has been loaded to the output. It is 0 again from the handshake carrying `in_last` until the next start word is loaded.
- R7: While `out_valid`=1 and `out_ready`=0, the output word and flag hold unchanged on the next cycle.
- R8: Single-Dword frames and frames offered back to back with no idle cycle are framed correctly, each with its own reseeded CRC and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 32 | Payload Dword |
| in_valid | input | 1 | Payload Dword offered |
| in_last | input | 1 | Offered Dword ends the payload |
| in_ready | output | 1 | Payload Dword accepted this cycle when valid |
| out_data | output | 32 | Framed output word |
| out_ctrl | output | 1 | 1 marks a primitive, 0 a data word |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the output word |

## Verification
The output is a single register. A payload Dword accepted at one clock edge is visible on `out_data` just after that edge. The start word appears one edge after `in_valid` is seen idle-side. The check word and end word each follow one accepted output transfer later. `in_ready` is combinational on the current state and `out_ready`, so the bench drives inputs at the falling edge and samples every handshake one nanosecond before the rising edge. It compares the transferred words, in order, against a queue that bench functions build from the CRC and LFSR definitions, so the result does not depend on how many stall cycles randomized backpressure inserts.

// File: rtl/lft_pkg.sv
package lft_pkg;
  localparam int unsigned DW = 32;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CHK  = 2'd2,
    ST_END  = 2'd3
  } lft_state_t;
endpackage

// File: rtl/lft_crc32.sv
module lft_crc32 #(
  parameter int unsigned          W    = 32,
  parameter logic [W-1:0]         POLY = 32'h04C11DB7,
  parameter logic [W-1:0]         INIT = 32'h52325032
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         update,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_nx;

  always_comb begin
    crc_nx = crc_q;
    for (int i = W - 1; i >= 0; i--) begin
      if (crc_nx[W-1] ^ din[i]) crc_nx = (crc_nx << 1) ^ POLY;
      else                      crc_nx = crc_nx << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         crc_q <= INIT;
    else if (clear)  crc_q <= INIT;
    else if (update) crc_q <= crc_nx;
  end

  assign crc = crc_q;

  // R3: a clear always leaves the initial value for the next frame
  p_crc_reload_r3: assert property (@(posedge clk) disable iff (rst)
    clear |=> crc_q == INIT);
endmodule

// File: rtl/lft_scrambler.sv
module lft_scrambler #(
  parameter int unsigned  SW   = 16,
  parameter int unsigned  MW   = 32,
  parameter logic [SW-1:0] TAPS = 16'hD008,
  parameter logic [SW-1:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reseed,
  input  logic          advance,
  output logic [MW-1:0] mask
);
  logic [SW-1:0] lfsr_q;
  logic [SW-1:0] lfsr_nx;

  always_comb begin
    lfsr_nx = lfsr_q;
    mask    = '0;
    for (int i = MW - 1; i >= 0; i--) begin
      mask[i] = lfsr_nx[SW-1];
      lfsr_nx = {lfsr_nx[SW-2:0], ^(lfsr_nx & TAPS)};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          lfsr_q <= SEED;
    else if (reseed)  lfsr_q <= SEED;
    else if (advance) lfsr_q <= lfsr_nx;
  end

  // R4: the generator never falls into the all-zero lock-up state
  p_lfsr_live_r4: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx #(
  parameter int unsigned  DW       = lft_pkg::DW,
  parameter logic [DW-1:0] SOF_WORD = 32'h3737B57C,
  parameter logic [DW-1:0] EOF_WORD = 32'hD5D5B57C,
  parameter logic [DW-1:0] CRC_POLY = 32'h04C11DB7,
  parameter logic [DW-1:0] CRC_INIT = 32'h52325032,
  parameter int unsigned  SCR_W    = 16,
  parameter logic [SCR_W-1:0] SCR_TAPS = 16'hD008,
  parameter logic [SCR_W-1:0] SCR_SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic          in_ready,
  output logic [DW-1:0] out_data,
  output logic          out_ctrl,
  output logic          out_valid,
  input  logic          out_ready
);
  import lft_pkg::*;

  lft_state_t    state_q;
  logic [DW-1:0] data_q;
  logic          ctrl_q;
  logic          valid_q;
  logic          adv;
  logic          take_in;
  logic          start_frame;
  logic          emit_chk;
  logic [DW-1:0] crc_val;
  logic [DW-1:0] scr_mask;

  assign adv         = !valid_q || out_ready;
  assign in_ready    = (state_q == ST_DATA) && adv;
  assign take_in     = in_valid && in_ready;
  assign start_frame = (state_q == ST_IDLE) && adv && in_valid;
  assign emit_chk    = (state_q == ST_CHK) && adv;

  lft_crc32 #(.W(DW), .POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
    .clk    (clk),
    .rst    (rst),
    .clear  (start_frame),
    .update (take_in),
    .din    (in_data),
    .crc    (crc_val)
  );

  lft_scrambler #(.SW(SCR_W), .MW(DW), .TAPS(SCR_TAPS), .SEED(SCR_SEED)) scr_i (
    .clk     (clk),
    .rst     (rst),
    .reseed  (start_frame),
    .advance (take_in || emit_chk),
    .mask    (scr_mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      ctrl_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (adv) begin
      unique case (state_q)
        ST_IDLE: begin
          valid_q <= in_valid;
          if (in_valid) begin
            data_q  <= SOF_WORD;
            ctrl_q  <= 1'b1;
            state_q <= ST_DATA;
          end
        end
        ST_DATA: begin
          valid_q <= in_valid;
          if (in_valid) begin
            data_q <= in_data ^ scr_mask;
            ctrl_q <= 1'b0;
            if (in_last) state_q <= ST_CHK;
          end
        end
        ST_CHK: begin
          data_q  <= crc_val ^ scr_mask;
          ctrl_q  <= 1'b0;
          valid_q <= 1'b1;
          state_q <= ST_END;
        end
        default: begin
          data_q  <= EOF_WORD;
          ctrl_q  <= 1'b1;
          valid_q <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign out_data  = data_q;
  assign out_ctrl  = ctrl_q;
  assign out_valid = valid_q;

  // R5: control-flagged words are only the two unmasked primitives
  p_ctrl_code_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ctrl) |-> (out_data == SOF_WORD || out_data == EOF_WORD));

  // R7: a refused word is held
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctrl)));

  // R6: payload is never accepted while an end primitive waits at the output
  p_stall_end_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ctrl && out_data == EOF_WORD) |-> !in_ready);

  // R2: a start primitive is never followed directly by another
  p_single_sof_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_ctrl && out_data == SOF_WORD)
      |=> !(out_valid && out_ctrl && out_data == SOF_WORD));
endmodule

// File: tb/lnk_frame_tx_tb_top.sv
module lnk_frame_tx_tb_top;
  localparam logic [31:0] SOF_W = 32'h3737B57C;
  localparam logic [31:0] EOF_W = 32'hD5D5B57C;
  localparam int NFR   = 60;
  localparam int LIMIT = 40000;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] in_data;
  logic        in_valid, in_last, in_ready;
  logic [31:0] out_data;
  logic        out_ctrl, out_valid, out_ready;

  always #5 clk = ~clk;

  lnk_frame_tx dut_i (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_data(out_data),
    .out_ctrl(out_ctrl), .out_valid(out_valid), .out_ready(out_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%09h expected=%09h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_ref(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r = c;
    for (int i = 31; i >= 0; i--) begin
      logic fb = r[31] ^ d[i];
      r = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [47:0] scr_ref(input logic [15:0] s);
    logic [15:0] r = s;
    logic [31:0] m;
    for (int i = 31; i >= 0; i--) begin
      m[i] = r[15];
      r = {r[14:0], r[15] ^ r[14] ^ r[12] ^ r[3]};
    end
    return {r, m};
  endfunction

  logic [31:0] fr[$];

  task automatic build_frame(input int f);
    logic [31:0] c = 32'h52325032;
    logic [15:0] s = 16'hFFFF;
    logic [47:0] sr;
    int len;
    fr.delete();
    if (f < 2)       len = 1;
    else if (f == 2) len = 16;
    else             len = 1 + ($urandom % 12);
    for (int i = 0; i < len; i++) begin
      if (f == 0)      fr.push_back(32'h0);
      else if (f == 2) fr.push_back(32'hFFFF_FFFF);
      else             fr.push_back($urandom);
    end
    exp_q.push_back({1'b1, SOF_W}); tag_q.push_back("R5 start word");
    foreach (fr[i]) begin
      sr = scr_ref(s); s = sr[47:32];
      exp_q.push_back({1'b0, fr[i] ^ sr[31:0]}); tag_q.push_back("R4 masked payload");
      c = crc_ref(c, fr[i]);
    end
    sr = scr_ref(s);
    exp_q.push_back({1'b0, c ^ sr[31:0]}); tag_q.push_back("R3 check word");
    exp_q.push_back({1'b1, EOF_W}); tag_q.push_back("R5 end word");
  endtask

  initial begin
    int fidx = 0;
    int pos = 0;
    int done = 0;
    int cyc = 0;
    bit need_new = 1'b1;
    bit opened = 1'b0;
    bit held = 1'b0;
    bit dense;
    logic [32:0] held_w;
    logic [32:0] e;
    string t;
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #4;
    check(out_valid == 1'b0, "R1 out_valid after reset", {32'b0, out_valid}, 33'd0);
    check(in_ready == 1'b0, "R1 in_ready after reset", {32'b0, in_ready}, 33'd0);
    while ((done < NFR || exp_q.size() != 0) && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
      if (need_new && fidx < NFR) begin
        build_frame(fidx);
        need_new = 1'b0;
        pos = 0;
      end
      dense     = (fidx < 8) || (fidx % 5 == 0);
      out_ready = dense ? 1'b1 : (($urandom % 4) != 0);
      in_valid  = !need_new && (dense || (($urandom % 4) != 0));
      in_data   = need_new ? 32'h0 : fr[pos];
      in_last   = !need_new && (pos == fr.size() - 1);
      #4;
      if (held) begin
        check(out_valid && {out_ctrl, out_data} == held_w, "R7 held word",
              {out_ctrl, out_data}, held_w);
        held = 1'b0;
      end
      if (out_valid && out_ctrl && out_data == SOF_W) opened = 1'b1;
      if (in_ready) check(opened, "R6 in_ready before start loaded", 33'd1, 33'd0);
      if (out_valid && !out_ready) begin
        held = 1'b1;
        held_w = {out_ctrl, out_data};
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected word", {out_ctrl, out_data}, 33'h0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({out_ctrl, out_data} == e, $sformatf("R2 %s", t), {out_ctrl, out_data}, e);
          if (e == {1'b1, EOF_W}) done++;
        end
      end
      if (in_valid && in_ready) begin
        pos++;
        if (pos == fr.size()) begin
          need_new = 1'b1;
          fidx++;
          opened = 1'b0;
        end
      end
    end
    if (cyc >= LIMIT) check(1'b0, "watchdog expired", cyc, LIMIT);
    check(done == NFR, "R8 frames completed", done, NFR);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule